// File: doc/BRIEF.md
# Half-Wave Symmetric Sine Lookup

This block turns a phase word into a 16-bit offset-binary sine sample. Only the positive half of the period is stored, as a table of 2^LUT_SZ samples at or above midscale. The top phase bit says which half of the cycle is wanted. The bits just below it pick a table entry, and the bits below those are dropped.

For the negative half, the sample is the stored word with every bit flipped. That flip happens only after the table's clocked read register, and the table has no logic in front of that register, so synthesis can still map the table to block RAM. The top phase bit travels through a matching register so that it reaches the flip in the same cycle as its table word. A second register after the flip gives a fixed two-cycle latency.

A parameter can turn the flip off. The block then produces the rectified wave, which is the stored half-wave repeated every half period. A phase accumulator ahead of the block and a converter interface after it are outside this design.

Top module: `sine_halfwave_lut`

## Requirements
- R1: `sample_valid` rises exactly two rising clock edges after `phase_valid` is sampled high. Back-to-back valid phases give back-to-back valid samples, one per cycle.
- R2: The table index is `phase[PHASE_W-2 : PHASE_W-1-LUT_SZ]`. With the defaults this is `phase[14:7]`. Phase bits below the index have no effect on the sample.
- R3: Table entry i equals 32768 + floor(32767 * sin(pi * i / 256) + 0.5) with the defaults. Entry 0 is 0x8000 and entry 128 is 0xFFFF.
- R4: When `phase[PHASE_W-1]` is 0, the sample equals the indexed table entry, so it is never below 0x8000.
- R5: When `phase[PHASE_W-1]` is 1 and mirroring is on, the sample is the entry XOR 0xFFFF. This is a bit inversion, not negation. Index 0 gives 0x7FFF and index 128 gives 0x0000.
- R6: With `MIRROR_EN` = 0, the sample equals the indexed entry whatever `phase[PHASE_W-1]` is, so its top bit is always 1.
- R7: While `sample_valid` is low, `sample` keeps its last value.
- R8: Reset drives `sample_valid` and `sample` to 0. It leaves the table contents unchanged, so samples read after a reset match samples read before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the table read clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_valid | input | 1 | Qualifies `phase` in this cycle |
| phase | input | PHASE_W (16) | Phase word; the top bit selects the half-cycle |
| sample_valid | output | 1 | The sample was produced this cycle |
| sample | output | SAMPLE_W (16) | Offset-binary sine sample |

## Verification
Directed phases at index 0 and index 128 in both halves pin the exact code values. They separate bit inversion from two's-complement negation, and they show any misplaced midscale. Pairs of phases that differ only below the index show that those bits are ignored, and a wrong address slice shows up as a different sample. Random phases with random valid gaps are checked against a model of the stored half-wave, comparing the mirrored instance with a non-mirrored one; this catches a wrong delay on the half-select bit, a wrong latency, and a sample that moves while idle. A reset in the middle of the run, followed by the same directed phases, shows that the table survives reset.

// File: rtl/sine_lut_pkg.sv
package sine_lut_pkg;

    localparam int DEF_PHASE_W  = 16;
    localparam int DEF_LUT_SZ   = 8;
    localparam int DEF_SAMPLE_W = 16;
    localparam real PI_R        = 3.14159265358979323846;

    // Control that travels alongside a table read.
    typedef struct packed {
        logic valid;
        logic upper;   // second half-cycle requested
    } lut_ctl_t;

    // Offset-binary code of the positive half-wave at slot idx of depth.
    function automatic logic [31:0] half_wave_code(input int idx, input int depth,
                                                   input int sample_w);
        real amp;
        real ang;
        int  mid;
        int  val;
        mid = 1 << (sample_w - 1);
        amp = real'(mid - 1);
        ang = PI_R * real'(idx) / real'(depth);
        val = mid + int'($floor(amp * $sin(ang) + 0.5));
        return 32'(val);
    endfunction

endpackage

// File: rtl/sine_phase_split.sv
module sine_phase_split
    import sine_lut_pkg::*;
#(
    parameter int PHASE_W = DEF_PHASE_W,
    parameter int LUT_SZ  = DEF_LUT_SZ
) (
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               valid_i,
    output logic [LUT_SZ-1:0]  addr_o,
    output lut_ctl_t           ctl_o
);
    localparam int LOW_W = PHASE_W - 1 - LUT_SZ;

    always_comb begin
        addr_o      = phase_i[PHASE_W-2 -: LUT_SZ];
        ctl_o.valid = valid_i;
        ctl_o.upper = phase_i[PHASE_W-1];
    end

    generate
        if (LOW_W > 0) begin : g_low
            logic unused_low;
            assign unused_low = ^phase_i[LOW_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/sine_half_rom.sv
module sine_half_rom
    import sine_lut_pkg::*;
#(
    parameter int LUT_SZ   = DEF_LUT_SZ,
    parameter int SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic                clk,
    input  logic [LUT_SZ-1:0]   addr_i,
    output logic [SAMPLE_W-1:0] data_o
);
    localparam int DEPTH = 1 << LUT_SZ;

    logic [SAMPLE_W-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = SAMPLE_W'(half_wave_code(i, DEPTH, SAMPLE_W));
        end
    end

    // Plain registered read: nothing between the array and data_o.
    always_ff @(posedge clk) begin
        data_o <= mem[addr_i];
    end
endmodule

// File: rtl/sine_mirror_stage.sv
module sine_mirror_stage
    import sine_lut_pkg::*;
#(
    parameter int SAMPLE_W  = DEF_SAMPLE_W,
    parameter bit MIRROR_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  lut_ctl_t            ctl_i,
    input  logic [SAMPLE_W-1:0] rom_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                valid_o
);
    lut_ctl_t            ctl_q;
    logic [SAMPLE_W-1:0] flip_mask;
    logic [SAMPLE_W-1:0] mirrored;

    // Align the half-select with the registered table word.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_i;
        end
    end

    generate
        if (MIRROR_EN) begin : g_mirror
            assign flip_mask = {SAMPLE_W{ctl_q.upper}};
        end else begin : g_rectify
            logic unused_upper;
            assign unused_upper = ctl_q.upper;
            assign flip_mask    = '0;
        end
    endgenerate

    assign mirrored = rom_i ^ flip_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= ctl_q.valid;
            if (ctl_q.valid) begin
                sample_o <= mirrored;
            end
        end
    end
endmodule

// File: rtl/sine_halfwave_lut.sv
module sine_halfwave_lut
    import sine_lut_pkg::*;
#(
    parameter int PHASE_W   = DEF_PHASE_W,
    parameter int LUT_SZ    = DEF_LUT_SZ,
    parameter int SAMPLE_W  = DEF_SAMPLE_W,
    parameter bit MIRROR_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                phase_valid,
    input  logic [PHASE_W-1:0]  phase,
    output logic                sample_valid,
    output logic [SAMPLE_W-1:0] sample
);
    logic [LUT_SZ-1:0]   rd_addr;
    lut_ctl_t            rd_ctl;
    logic [SAMPLE_W-1:0] rom_word;

    sine_phase_split #(.PHASE_W(PHASE_W), .LUT_SZ(LUT_SZ)) u_split (
        .phase_i (phase),
        .valid_i (phase_valid),
        .addr_o  (rd_addr),
        .ctl_o   (rd_ctl)
    );

    sine_half_rom #(.LUT_SZ(LUT_SZ), .SAMPLE_W(SAMPLE_W)) u_rom (
        .clk    (clk),
        .addr_i (rd_addr),
        .data_o (rom_word)
    );

    sine_mirror_stage #(.SAMPLE_W(SAMPLE_W), .MIRROR_EN(MIRROR_EN)) u_mirror (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (rd_ctl),
        .rom_i    (rom_word),
        .sample_o (sample),
        .valid_o  (sample_valid)
    );
endmodule

// File: rtl/sine_halfwave_lut_chk.sv
module sine_halfwave_lut_chk #(
    parameter int PHASE_W   = 16,
    parameter int SAMPLE_W  = 16,
    parameter bit MIRROR_EN = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic                phase_valid,
    input logic [PHASE_W-1:0]  phase,
    input logic                sample_valid,
    input logic [SAMPLE_W-1:0] sample
);
    localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);

    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst) cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    p_first_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd0) |-> (!sample_valid && sample == '0));

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> (sample_valid == $past(phase_valid, 2)));

    p_low_half_r4: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && sample_valid && !$past(phase[PHASE_W-1], 2)) |-> (sample >= MID));

    p_high_half_r5: assert property (@(posedge clk) disable iff (rst)
        (MIRROR_EN && cyc >= 2'd2 && sample_valid) |->
            (sample[SAMPLE_W-1] == !$past(phase[PHASE_W-1], 2)));

    p_rectified_r6: assert property (@(posedge clk) disable iff (rst)
        (!MIRROR_EN && sample_valid) |-> sample[SAMPLE_W-1]);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && !sample_valid) |-> $stable(sample));
endmodule

bind sine_halfwave_lut sine_halfwave_lut_chk #(
    .PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .MIRROR_EN(MIRROR_EN)
) u_chk (
    .clk(clk), .rst(rst), .phase_valid(phase_valid), .phase(phase),
    .sample_valid(sample_valid), .sample(sample)
);

// File: tb/sine_halfwave_lut_test.sv
`timescale 1ns/1ps
module sine_halfwave_lut_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phase_valid = 1'b0;
    logic [15:0] phase = '0;
    logic        sample_valid, abs_valid;
    logic [15:0] sample, abs_sample;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    sine_halfwave_lut uut (
        .clk(clk), .rst(rst), .phase_valid(phase_valid), .phase(phase),
        .sample_valid(sample_valid), .sample(sample)
    );

    sine_halfwave_lut #(.MIRROR_EN(1'b0)) uut_abs (
        .clk(clk), .rst(rst), .phase_valid(phase_valid), .phase(phase),
        .sample_valid(abs_valid), .sample(abs_sample)
    );

    // Spec R3: 32768 + floor(32767*sin(pi*i/256)+0.5)
    function automatic logic [15:0] ref_entry(input int i);
        real s;
        s = $sin(3.14159265358979323846 * real'(i) / 256.0);
        return 16'(32768 + int'($floor(32767.0 * s + 0.5)));
    endfunction

    function automatic logic [15:0] ref_sample(input logic [15:0] ph, input bit mirror);
        logic [15:0] e;
        e = ref_entry(int'(ph[14:7]));
        if (mirror && ph[15]) e = e ^ 16'hFFFF;
        return e;
    endfunction

    // Two-deep history of driven inputs.
    logic        h1_v = 0, h2_v = 0;
    logic [15:0] h1_p = '0, h2_p = '0;
    string       h1_t = "", h2_t = "";
    logic [15:0] hold_m = '0, hold_a = '0;

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs();
        string hreq;
        if (h2_v) begin
            hold_m = ref_sample(h2_p, 1'b1);
            hold_a = ref_sample(h2_p, 1'b0);
        end
        hreq = h2_v ? (h2_p[15] ? "R5" : "R4") : "R7";
        check(sample_valid == h2_v, "R1 valid", 16'(sample_valid), 16'(h2_v));
        check(sample == hold_m, {hreq, " ", h2_t}, sample, hold_m);
        check(abs_sample == hold_a, {"R6 ", h2_t}, abs_sample, hold_a);
    endtask

    task automatic step(input logic v, input logic [15:0] ph, input string tag);
        @(negedge clk);
        if (done) return;
        check_outputs();
        h2_v = h1_v; h2_p = h1_p; h2_t = h1_t;
        h1_v = v;    h1_p = ph;   h1_t = tag;
        phase_valid = v;
        phase       = ph;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        phase_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!sample_valid, "R8 valid after reset", 16'(sample_valid), 16'h0);
        check(sample == 16'h0, "R8 sample after reset", sample, 16'h0);
        rst = 1'b0;
        h1_v = 0; h2_v = 0; hold_m = '0; hold_a = '0;
    endtask

    task automatic directed(input string tag);
        step(1, 16'h0000, {tag, " R3 idx0 low"});
        step(1, 16'h8000, {tag, " R5 idx0 high"});
        step(1, 16'h4000, {tag, " R3 peak low"});
        step(1, 16'hC000, {tag, " R5 peak high"});
        step(1, 16'h407F, {tag, " R2 low bits set"});
        step(0, 16'h1234, {tag, " R7 idle"});
        step(0, 16'hFFFF, {tag, " R7 idle"});
        step(1, 16'hFF80, {tag, " R2 last idx"});
        step(1, 16'h7FFF, {tag, " R2 last idx low"});
        step(0, 16'h0000, {tag, " flush"});
        step(0, 16'h0000, {tag, " flush"});
    endtask

    // Spot checks of the model against the fixed codes named in R3/R5.
    initial begin
        if (ref_entry(0) != 16'h8000 || ref_entry(128) != 16'hFFFF)
            $display("note: reference table endpoints unexpected");
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4321);
        do_reset();
        directed("pre");
        for (int n = 0; n < 400; n++) begin
            logic        v;
            logic [15:0] p;
            v = ($urandom % 4) != 0;
            p = 16'($urandom);
            step(v, p, "random");
        end
        step(0, 16'h0, "flush");
        step(0, 16'h0, "flush");
        do_reset();
        directed("post-reset R8");
        step(0, 16'h0, "flush");
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%h expected=%h", 16'h1, 16'h0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule